// File: doc/BRIEF.md
# Nibble-Coded Sixteen-Register Multi-Cycle Processor

A small multi-cycle processor for teaching. It has sixteen 8-bit general registers, an 8-bit program counter and a 16-bit instruction register. It runs from an internal 256-byte memory. Every instruction takes two bytes. The top hex digit selects the operation, and the next three hex digits name registers, an address or an immediate.

While the core is idle or halted, a testbench or host fills memory through a byte-wide valid/ready load stream. A one-cycle `start` pulse then begins execution at address 00. The core fetches, decodes and executes until it reaches a halt instruction or an illegal one. The caller then reads the result through plain debug read ports for registers and memory, together with the PC, the IR and the status flags.

The load stream applies back-pressure by state alone. `ld_ready` is high exactly when the core is not running. A byte is written only in a cycle where `ld_valid` and `ld_ready` are both high. A byte offered while the core runs waits and is never written in the middle of a program.

Top module: `nibble_cpu`

## Requirements
- R1: After reset the core is idle: `busy`=0, `halted`=0, `illegal`=0, `pc`=00, `ir`=0000, all registers 00. A `start` pulse while the core is not busy clears `illegal`, sets `pc` to 00 and begins execution.
- R2: Fetch places the byte at `pc` in `ir[15:8]` and the byte at `pc+1` in `ir[7:0]`, then advances `pc` by 2. The address wraps from FF to 00.
- R3: Opcode 1 (`1rab`) loads register r from memory address ab. Opcode 2 loads register r with the immediate ab. Opcode 3 writes register r to memory address ab.
- R4: Opcode 4 (`4xrs`) copies register r (bits 7:4) into register s (bits 3:0). Bits 11:8 are ignored.
- R5: Opcodes 5, 7, 8 and 9 (`oRST`) write S+T modulo 256, S OR T, S AND T and S XOR T into R.
- R6: Opcode A (`Ar0n`) rotates register r right n mod 8 times, with the low bit re-entering at the top. A count of 0 or 8 leaves the register unchanged.
- R7: Opcode B (`Brab`) sets `pc` to ab when register r equals register 0. Otherwise execution continues with the next instruction. Register 0 is an ordinary writable register.
- R8: Opcode C stops the core. `halted`=1, and `pc`, `ir` and the registers then hold until the next `start`.
- R9: Opcodes 0, 6, D, E and F set `illegal` and halt the core.
- R10: `ld_ready` equals NOT `busy`. A byte is written only when `ld_valid` and `ld_ready` are both high, so a byte offered while the core is busy is not written.
- R11: An instruction takes 4 clocks (fetch 3, execute 1). A memory load takes 5 clocks. A program of load, store and halt sets `halted` on the 13th rising edge after the edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at address 00 (ignored while busy) |
| ld_valid | input | 1 | Load-stream byte valid |
| ld_ready | output | 1 | Load stream accepts a byte (core not running) |
| ld_addr | input | 8 | Memory address of the offered byte |
| ld_data | input | 8 | Offered byte |
| busy | output | 1 | Core is executing |
| halted | output | 1 | Core stopped by halt or illegal opcode |
| illegal | output | 1 | Last stop was caused by an illegal opcode |
| pc | output | 8 | Program counter |
| ir | output | 16 | Instruction register |
| dbg_reg_sel | input | 4 | Register index for debug read |
| dbg_reg_data | output | 8 | Contents of the selected register |
| dbg_mem_addr | input | 8 | Memory address for debug read |
| dbg_mem_data | output | 8 | Contents of the selected memory byte |

## Verification
Checks made on every cycle:
- The load stream's readiness always mirrors the busy state.
- Busy and halted are never both high.
- `illegal` implies the core is halted.
- Each fetch advances the PC by exactly two, with wrap.
- `start` from rest lands at address 00.
- A halted core keeps its PC and IR.
- A memory-load opcode always passes through the extra memory cycle.

Checks that only the bench's programs can make:
- The data results of loads, stores, moves, arithmetic, logic and rotation.
- Whether a conditional jump is taken.
- Wraparound of the PC past FF.
- Rejection of a byte offered mid-run.
- The exact clock count of a short program.

// File: rtl/ncpu_pkg.sv
package ncpu_pkg;
  localparam int NIB = 4;

  localparam logic [NIB-1:0] OPC_LDM = 4'h1;
  localparam logic [NIB-1:0] OPC_LDI = 4'h2;
  localparam logic [NIB-1:0] OPC_STM = 4'h3;
  localparam logic [NIB-1:0] OPC_MOV = 4'h4;
  localparam logic [NIB-1:0] OPC_ADD = 4'h5;
  localparam logic [NIB-1:0] OPC_OR  = 4'h7;
  localparam logic [NIB-1:0] OPC_AND = 4'h8;
  localparam logic [NIB-1:0] OPC_XOR = 4'h9;
  localparam logic [NIB-1:0] OPC_ROR = 4'hA;
  localparam logic [NIB-1:0] OPC_JEQ = 4'hB;
  localparam logic [NIB-1:0] OPC_HLT = 4'hC;

  typedef enum logic [2:0] {
    FN_ADD, FN_OR, FN_AND, FN_XOR, FN_ROR
  } alu_fn_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_F0, ST_F1, ST_F2, ST_EX, ST_LD, ST_HALT
  } state_e;
endpackage

// File: rtl/ncpu_mem.sv
module ncpu_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end

  assign dbg_data = cells[dbg_addr];
endmodule

// File: rtl/ncpu_regfile.sv
module ncpu_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 16,
  parameter int NRD  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [$clog2(NREG)-1:0] raddr [NRD],
  output logic [DW-1:0]           rdata [NRD],
  input  logic [$clog2(NREG)-1:0] dbg_sel,
  output logic [DW-1:0]           dbg_data
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = regs[raddr[p]];
  end

  assign dbg_data = regs[dbg_sel];
endmodule

// File: rtl/ncpu_alu.sv
module ncpu_alu
  import ncpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_fn_e                 fn,
  input  logic [DW-1:0]           a,
  input  logic [DW-1:0]           b,
  input  logic [$clog2(DW)-1:0]   rot,
  output logic [DW-1:0]           y
);
  logic [2*DW-1:0] doubled;

  always_comb begin
    doubled = {a, a} >> rot;
    unique case (fn)
      FN_ADD:  y = a + b;
      FN_OR:   y = a | b;
      FN_AND:  y = a & b;
      FN_XOR:  y = a ^ b;
      FN_ROR:  y = doubled[DW-1:0];
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/nibble_cpu.sv
module nibble_cpu
  import ncpu_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    ld_valid,
  output logic                    ld_ready,
  input  logic [AW-1:0]           ld_addr,
  input  logic [DW-1:0]           ld_data,
  output logic                    busy,
  output logic                    halted,
  output logic                    illegal,
  output logic [AW-1:0]           pc,
  output logic [2*DW-1:0]         ir,
  input  logic [$clog2(NREG)-1:0] dbg_reg_sel,
  output logic [DW-1:0]           dbg_reg_data,
  input  logic [AW-1:0]           dbg_mem_addr,
  output logic [DW-1:0]           dbg_mem_data
);
  localparam int RIW = $clog2(NREG);
  localparam int RW  = $clog2(DW);
  localparam int NRD = 4;

  state_e state;
  logic   illegal_q;

  logic [NIB-1:0] f_op, f_r, f_s, f_t;
  logic [DW-1:0]  f_imm;
  assign f_op  = ir[4*NIB-1:3*NIB];
  assign f_r   = ir[3*NIB-1:2*NIB];
  assign f_s   = ir[2*NIB-1:NIB];
  assign f_t   = ir[NIB-1:0];
  assign f_imm = ir[DW-1:0];

  assign busy     = (state != ST_IDLE) && (state != ST_HALT);
  assign halted   = (state == ST_HALT);
  assign illegal  = illegal_q;
  assign ld_ready = !busy;

  // register file: ports 0..3 read R, S, T and register 0
  logic [RIW-1:0] rd_addr [NRD];
  logic [DW-1:0]  rd_data [NRD];
  logic           rf_we;
  logic [RIW-1:0] rf_wa;
  logic [DW-1:0]  rf_wd;

  assign rd_addr[0] = RIW'(f_r);
  assign rd_addr[1] = RIW'(f_s);
  assign rd_addr[2] = RIW'(f_t);
  assign rd_addr[3] = '0;

  ncpu_regfile #(.DW(DW), .NREG(NREG), .NRD(NRD)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_wa), .wdata(rf_wd),
    .raddr(rd_addr), .rdata(rd_data),
    .dbg_sel(dbg_reg_sel), .dbg_data(dbg_reg_data)
  );

  // memory
  logic          m_we;
  logic [AW-1:0] m_waddr, m_raddr;
  logic [DW-1:0] m_wdata, m_rdata;
  logic          store_now;

  assign store_now = (state == ST_EX) && (f_op == OPC_STM);
  assign m_we      = store_now || (ld_valid && ld_ready);
  assign m_waddr   = busy ? AW'(f_imm) : ld_addr;
  assign m_wdata   = busy ? rd_data[0] : ld_data;

  always_comb begin
    unique case (state)
      ST_F0:   m_raddr = pc;
      ST_F1:   m_raddr = pc + AW'(1);
      default: m_raddr = AW'(f_imm);
    endcase
  end

  ncpu_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we(m_we), .waddr(m_waddr), .wdata(m_wdata),
    .raddr(m_raddr), .rdata(m_rdata),
    .dbg_addr(dbg_mem_addr), .dbg_data(dbg_mem_data)
  );

  // ALU
  alu_fn_e       fn;
  logic [DW-1:0] alu_a, alu_y;

  always_comb begin
    unique case (f_op)
      OPC_OR:  fn = FN_OR;
      OPC_AND: fn = FN_AND;
      OPC_XOR: fn = FN_XOR;
      OPC_ROR: fn = FN_ROR;
      default: fn = FN_ADD;
    endcase
  end

  assign alu_a = (f_op == OPC_ROR) ? rd_data[0] : rd_data[1];

  ncpu_alu #(.DW(DW)) u_alu (
    .fn(fn), .a(alu_a), .b(rd_data[2]), .rot(f_t[RW-1:0]), .y(alu_y)
  );

  // register write-back
  always_comb begin
    rf_we = 1'b0;
    rf_wa = RIW'(f_r);
    rf_wd = alu_y;
    if (state == ST_LD) begin
      rf_we = 1'b1;
      rf_wd = m_rdata;
    end else if (state == ST_EX) begin
      unique case (f_op)
        OPC_LDI: begin rf_we = 1'b1; rf_wd = f_imm; end
        OPC_MOV: begin rf_we = 1'b1; rf_wa = RIW'(f_t); rf_wd = rd_data[1]; end
        OPC_ADD, OPC_OR, OPC_AND, OPC_XOR, OPC_ROR: rf_we = 1'b1;
        default: rf_we = 1'b0;
      endcase
    end
  end

  // sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pc        <= '0;
      ir        <= '0;
      illegal_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE, ST_HALT: if (start) begin
          state     <= ST_F0;
          pc        <= '0;
          illegal_q <= 1'b0;
        end
        ST_F0: state <= ST_F1;
        ST_F1: begin
          ir[2*DW-1:DW] <= m_rdata;
          state         <= ST_F2;
        end
        ST_F2: begin
          ir[DW-1:0] <= m_rdata;
          pc         <= pc + AW'(2);
          state      <= ST_EX;
        end
        ST_EX: begin
          unique case (f_op)
            OPC_LDM: state <= ST_LD;
            OPC_LDI, OPC_STM, OPC_MOV, OPC_ADD,
            OPC_OR, OPC_AND, OPC_XOR, OPC_ROR: state <= ST_F0;
            OPC_JEQ: begin
              if (rd_data[0] == rd_data[3]) pc <= AW'(f_imm);
              state <= ST_F0;
            end
            OPC_HLT: state <= ST_HALT;
            default: begin
              illegal_q <= 1'b1;
              state     <= ST_HALT;
            end
          endcase
        end
        ST_LD:   state <= ST_F0;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ncpu_checker.sv
module ncpu_checker
  import ncpu_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          halted,
  input logic          illegal,
  input logic          ld_ready,
  input logic [AW-1:0] pc,
  input logic [2*DW-1:0] ir,
  input state_e        state
);
  a_r10_ready_mirrors_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready == !busy);

  a_r8_busy_halt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && halted));

  a_r9_illegal_means_halted: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> halted);

  a_r2_fetch_adds_two: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_F2) |=> (pc == AW'($past(pc) + AW'(2))));

  a_r1_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (pc == '0 && busy && !illegal));

  a_r8_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !start) |=> (halted && $stable(pc) && $stable(ir)));

  a_r11_load_extra_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EX && ir[15:12] == OPC_LDM) |=> (state == ST_LD));
endmodule

bind nibble_cpu ncpu_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .halted(halted),
  .illegal(illegal), .ld_ready(ld_ready), .pc(pc), .ir(ir), .state(state)
);

// File: tb/sim_nibble_cpu.sv
module sim_nibble_cpu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [7:0]  ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic        busy, halted, illegal;
  logic [7:0]  pc;
  logic [15:0] ir;
  logic [3:0]  dbg_reg_sel = '0;
  logic [7:0]  dbg_reg_data;
  logic [7:0]  dbg_mem_addr = '0;
  logic [7:0]  dbg_mem_data;

  always #10 clk = ~clk;

  nibble_cpu u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data),
    .busy(busy), .halted(halted), .illegal(illegal), .pc(pc), .ir(ir),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data),
    .dbg_mem_addr(dbg_mem_addr), .dbg_mem_data(dbg_mem_data)
  );

  int nchk = 0;
  int nfail = 0;

  typedef enum int { K_REG, K_MEM, K_PC, K_IR, K_ILL, K_HALT } kind_e;
  typedef struct {
    kind_e       kind;
    int          idx;
    logic [15:0] val;
    string       tag;
  } exp_t;

  exp_t sb[$];

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_item(kind_e k, int idx, logic [15:0] v, string tag);
    exp_t e;
    e.kind = k; e.idx = idx; e.val = v; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: pops expected items and compares with what the ports show
  task automatic drain();
    while (sb.size() > 0) begin
      exp_t e;
      logic [15:0] act;
      e = sb.pop_front();
      dbg_reg_sel  = 4'(e.idx);
      dbg_mem_addr = 8'(e.idx);
      #1;
      case (e.kind)
        K_REG:   act = {8'h00, dbg_reg_data};
        K_MEM:   act = {8'h00, dbg_mem_data};
        K_PC:    act = {8'h00, pc};
        K_IR:    act = ir;
        K_ILL:   act = {15'd0, illegal};
        default: act = {15'd0, halted};
      endcase
      check(e.tag, act, e.val);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic put_byte(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_data = d;
    do @(posedge clk); while (!ld_ready);
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic put_word(logic [7:0] a, logic [15:0] w);
    put_byte(a, w[15:8]);
    put_byte(8'(a + 8'd1), w[7:0]);
  endtask

  // start the program; returns the edge count at which halted was seen
  task automatic run(output int edges, input bit poke);
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    edges = 0;
    while (edges < 2000) begin
      @(posedge clk);
      edges++;
      #1;
      if (halted) break;
      if (poke && edges == 3) begin
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = 8'h30; ld_data = 8'hAA;
        #1 check("R10 ld_ready low while busy", {15'd0, ld_ready}, 16'd0);
      end
      if (poke && edges == 5) ld_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] hold_pc;
    do_reset();
    #1;
    check("R1 busy after reset", {15'd0, busy}, 16'd0);
    check("R1 halted after reset", {15'd0, halted}, 16'd0);
    check("R1 pc after reset", {8'd0, pc}, 16'h0000);
    check("R1 ir after reset", ir, 16'h0000);
    check("R10 ready while idle", {15'd0, ld_ready}, 16'd1);

    // program A: memory load, store, halt; mid-run byte must be refused
    put_byte(8'h30, 8'h00);
    put_word(8'h00, 16'h1306);
    put_word(8'h02, 16'h3307);
    put_word(8'h04, 16'hC000);
    put_word(8'h06, 16'h87FF);
    run(n, 1'b1);
    check("R11 clocks to halt", 16'(n), 16'd13);
    expect_item(K_REG, 3, 16'h87, "R3 load from memory");
    expect_item(K_MEM, 7, 16'h87, "R3 store to memory");
    expect_item(K_MEM, 8'h30, 16'h00, "R10 busy byte ignored");
    expect_item(K_PC, 0, 16'h06, "R2 pc after halt fetch");
    expect_item(K_IR, 0, 16'hC000, "R2 ir holds halt word");
    expect_item(K_HALT, 0, 16'd1, "R8 halted set");
    expect_item(K_ILL, 0, 16'd0, "R9 halt is not illegal");
    drain();
    hold_pc = pc;
    repeat (5) @(posedge clk);
    #1 check("R8 pc held after halt", {8'd0, pc}, {8'd0, hold_pc});

    // program B: arithmetic, logic, move, rotate
    do_reset();
    put_word(8'h00, 16'h2105);
    put_word(8'h02, 16'h22FE);
    put_word(8'h04, 16'h5312);
    put_word(8'h06, 16'h7412);
    put_word(8'h08, 16'h8512);
    put_word(8'h0A, 16'h9612);
    put_word(8'h0C, 16'h4017);
    put_word(8'h0E, 16'hA703);
    put_word(8'h10, 16'h2881);
    put_word(8'h12, 16'hA800);
    put_word(8'h14, 16'h2991);
    put_word(8'h16, 16'hA909);
    put_word(8'h18, 16'hC000);
    run(n, 1'b0);
    expect_item(K_REG, 3, 16'h03, "R5 add wraps");
    expect_item(K_REG, 4, 16'hFF, "R5 or");
    expect_item(K_REG, 5, 16'h04, "R5 and");
    expect_item(K_REG, 6, 16'hFB, "R5 xor");
    expect_item(K_REG, 1, 16'h05, "R4 move keeps source");
    expect_item(K_REG, 7, 16'hA0, "R6 rotate by 3");
    expect_item(K_REG, 8, 16'h81, "R6 rotate by 0");
    expect_item(K_REG, 9, 16'hC8, "R6 rotate count 9 mod 8");
    expect_item(K_REG, 2, 16'hFE, "R3 immediate load");
    expect_item(K_PC, 0, 16'h1A, "R2 pc after 13 instructions");
    drain();

    // program C: conditional jump taken and not taken
    do_reset();
    put_word(8'h00, 16'h2007);
    put_word(8'h02, 16'h2107);
    put_word(8'h04, 16'hB108);
    put_word(8'h06, 16'h2255);
    put_word(8'h08, 16'h2309);
    put_word(8'h0A, 16'hB30E);
    put_word(8'h0C, 16'h2444);
    put_word(8'h0E, 16'hC000);
    run(n, 1'b0);
    expect_item(K_REG, 2, 16'h00, "R7 taken jump skips");
    expect_item(K_REG, 4, 16'h44, "R7 untaken jump falls through");
    expect_item(K_REG, 3, 16'h09, "R7 path after jump");
    expect_item(K_PC, 0, 16'h10, "R7 final pc");
    drain();

    // illegal opcodes, restart clears the flag
    do_reset();
    put_word(8'h00, 16'h6000);
    run(n, 1'b0);
    expect_item(K_ILL, 0, 16'd1, "R9 opcode 6 illegal");
    expect_item(K_HALT, 0, 16'd1, "R9 illegal halts");
    expect_item(K_PC, 0, 16'h02, "R9 pc after illegal");
    drain();
    put_word(8'h00, 16'hC000);
    run(n, 1'b0);
    expect_item(K_ILL, 0, 16'd0, "R1 start clears illegal");
    drain();
    put_word(8'h00, 16'hE123);
    run(n, 1'b0);
    expect_item(K_ILL, 0, 16'd1, "R9 opcode E illegal");
    drain();
    put_word(8'h00, 16'h0000);
    run(n, 1'b0);
    expect_item(K_ILL, 0, 16'd1, "R9 opcode 0 illegal");
    drain();

    // PC wrap from FF to 00
    put_word(8'h00, 16'hBAFE);
    put_word(8'h02, 16'hC000);
    put_word(8'hFE, 16'h2A11);
    run(n, 1'b0);
    expect_item(K_REG, 10, 16'h11, "R2 wrap executed FE");
    expect_item(K_PC, 0, 16'h04, "R2 wrap then fall through");
    expect_item(K_ILL, 0, 16'd0, "R8 clean halt after wrap");
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule